// File: doc/BRIEF.md
# KCS Shared Interrupt Merger

This block drives the single host interrupt line of a keyboard-controller-style management interface. Two sources share the line. The first is the output-buffer-full event raised by the protocol engine. The second is the attention event raised by the management controller. Each source has its own sticky pending flag. The line is high while either flag is set.

A source can become pending only when two conditions hold: the board has a strap that wires the interrupt, and a runtime enable bit is set. The two flags are cleared by different host reads. A read of the data register retires the output-buffer-full flag. A read of the status register retires the attention flag.

The block also holds the attention bit that is shown in the host status register. The attention request input writes that bit directly. Both pending flags are brought out on a debug port.

Top module: `kcs_irq_merge`

## Requirements
- R1: After reset the pending flags, the enable bit, the attention status bit and the interrupt line are all 0.
- R2: An output-full pulse sets the output-full pending flag (debug bit 0) when the strap is high and the enable is 1.
- R3: A host data read clears the output-full pending flag. The line stays high if the attention flag is still pending.
- R4: A host status read clears the attention pending flag (debug bit 1) and nothing else. The line stays high if the output-full flag is still pending. The attention status bit is unchanged.
- R5: An attention request writes its value into the attention status bit. If the value is 1 and an interrupt is asked for, the request also sets the attention pending flag, provided the strap and the enable allow it. Without the interrupt flag, the pending flag is untouched.
- R6: An attention request with value 0 clears both the attention status bit and the attention pending flag. The line stays high if the output-full flag is pending.
- R7: While the strap is low, neither pending flag becomes set and the line stays low. Attention requests still write the status bit.
- R8: While the enable is 0, no new pending flag is set. A flag that is already pending remains set until its own read clears it.
- R9: When a set and a clear of the same flag arrive in the same cycle, the set wins.
- R10: The line and the debug flags are registered. All results appear on the first clock edge after the stimulus, and the line always equals the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_wired | input | 1 | Static strap: the interrupt line is connected |
| irq_en_we | input | 1 | Write strobe for the interrupt enable |
| irq_en_d | input | 1 | New interrupt enable value |
| obf_set_pulse | input | 1 | Output buffer has just become full |
| atn_req | input | 1 | Attention set/clear request |
| atn_val | input | 1 | Attention value to write |
| atn_want_irq | input | 1 | The attention request asks for an interrupt |
| host_rd_data | input | 1 | Host read strobe of the data register |
| host_rd_status | input | 1 | Host read strobe of the status register |
| sms_atn | output | 1 | Attention bit for the status register |
| irq_line | output | 1 | Level-sensitive shared interrupt |
| pend_dbg | output | 2 | Pending flags: bit 0 is output-full, bit 1 is attention |

## Verification
All results register on the edge that samples the stimulus, so each result is due exactly one cycle later. This covers the flags, the line and the attention bit. A change to the enable takes effect on the stimulus of the following cycle.

The driver applies each stimulus on a falling edge and queues the expected line, flags and attention bit for that cycle. The monitor pops one entry just after each rising edge, so every comparison falls in the cycle where the result becomes due.

// File: rtl/kcs_irq_pkg.sv
package kcs_irq_pkg;
  localparam int NUM_SRC    = 2;
  localparam int SRC_OBF    = 0;
  localparam int SRC_ATN    = 1;
  localparam int RST_STAGES = 2;

  typedef struct packed {
    logic set;
    logic clr;
  } src_req_t;
endpackage

// File: rtl/kcs_rst_sync.sv
module kcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/kcs_irq_enable.sv
module kcs_irq_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic en_o
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (we) en_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // R1: the enable holds its value unless it is written
  a_r1_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_q));
endmodule

// File: rtl/kcs_atn_status.sv
module kcs_atn_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic val,
  output logic atn_o
);
  logic atn_q, atn_d;

  always_comb begin
    atn_d = atn_q;
    if (wr) atn_d = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) atn_q <= 1'b0;
    else        atn_q <= atn_d;
  end

  assign atn_o = atn_q;

  // R5: a request writes its value into the attention bit
  a_r5_atn_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (atn_q == $past(val)));
endmodule

// File: rtl/kcs_pend_flag.sv
module kcs_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic set_req,
  input  logic clr_req,
  output logic pend_o,
  output logic pend_nxt_o
);
  logic pend_q, pend_d;

  // a set has priority over a clear in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (clr_req)         pend_d = 1'b0;
    if (set_req && arm)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o     = pend_q;
  assign pend_nxt_o = pend_d;

  // R8: without arming, a clear flag stays clear
  a_r8_no_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !pend_q) |=> !pend_q);
  // R9: an armed set wins over a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && arm) |=> pend_q);
endmodule

// File: rtl/kcs_irq_merge.sv
module kcs_irq_merge
  import kcs_irq_pkg::*;
#(
  parameter int SYNC_STAGES = RST_STAGES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_wired,
  input  logic               irq_en_we,
  input  logic               irq_en_d,
  input  logic               obf_set_pulse,
  input  logic               atn_req,
  input  logic               atn_val,
  input  logic               atn_want_irq,
  input  logic               host_rd_data,
  input  logic               host_rd_status,
  output logic               sms_atn,
  output logic               irq_line,
  output logic [NUM_SRC-1:0] pend_dbg
);
  logic               rst_n_s;
  logic               en_q;
  logic               arm;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  src_req_t           req [NUM_SRC];
  logic               line_q, line_d;

  kcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s));

  kcs_irq_enable u_en (
    .clk(clk), .rst_n(rst_n_s), .we(irq_en_we), .d(irq_en_d), .en_o(en_q));

  kcs_atn_status u_atn (
    .clk(clk), .rst_n(rst_n_s), .wr(atn_req), .val(atn_val), .atn_o(sms_atn));

  assign arm = irq_wired & en_q;

  assign req[SRC_OBF].set = obf_set_pulse;
  assign req[SRC_OBF].clr = host_rd_data;
  assign req[SRC_ATN].set = atn_req & atn_val & atn_want_irq;
  assign req[SRC_ATN].clr = host_rd_status | (atn_req & ~atn_val);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    kcs_pend_flag u_flag (
      .clk(clk), .rst_n(rst_n_s), .arm(arm),
      .set_req(req[g].set), .clr_req(req[g].clr),
      .pend_o(pend_q[g]), .pend_nxt_o(pend_d[g]));
  end

  always_comb line_d = |pend_d;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) line_q <= 1'b0;
    else          line_q <= line_d;
  end

  assign irq_line = line_q;
  assign pend_dbg = pend_q;

  // R10: the registered line always matches the flags
  a_r10_line_matches: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_line == (|pend_dbg));
  // R2: an armed output-full pulse makes its flag pending
  a_r2_obf_sets: assert property (@(posedge clk) disable iff (!rst_n_s)
    (obf_set_pulse && irq_wired && en_q) |=> pend_dbg[SRC_OBF]);
  // R3: a data read with no new pulse retires the output-full flag
  a_r3_data_read_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_rd_data && !obf_set_pulse) |=> !pend_dbg[SRC_OBF]);
  // R4: a status read with no new set retires the attention flag
  a_r4_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_rd_status && !(atn_req && atn_val && atn_want_irq)) |=> !pend_dbg[SRC_ATN]);
  // R6: clearing attention drops both the bit and its flag
  a_r6_atn_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (atn_req && !atn_val) |=> (!sms_atn && !pend_dbg[SRC_ATN]));
  // R7: an unwired interrupt never becomes pending
  a_r7_unwired_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!irq_wired && pend_dbg == '0) |=> (pend_dbg == '0 && !irq_line));
endmodule

// File: tb/tb_kcs_irq_merge.sv
module tb_kcs_irq_merge;
  logic clk = 1'b0;
  logic rst_n;
  logic irq_wired, irq_en_we, irq_en_d, obf_set_pulse;
  logic atn_req, atn_val, atn_want_irq, host_rd_data, host_rd_status;
  logic sms_atn, irq_line;
  logic [1:0] pend_dbg;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       line;
    logic [1:0] pend;
    logic       atn;
    string      tag;
  } exp_t;
  exp_t q [$];

  always #5 clk = ~clk;

  kcs_irq_merge dut (
    .clk(clk), .rst_n(rst_n), .irq_wired(irq_wired), .irq_en_we(irq_en_we),
    .irq_en_d(irq_en_d), .obf_set_pulse(obf_set_pulse), .atn_req(atn_req),
    .atn_val(atn_val), .atn_want_irq(atn_want_irq), .host_rd_data(host_rd_data),
    .host_rd_status(host_rd_status), .sms_atn(sms_atn), .irq_line(irq_line),
    .pend_dbg(pend_dbg));

  // Drive one cycle of stimulus and queue what must appear after the next edge
  task automatic step(input logic obf, input logic rdd, input logic rds,
                      input logic areq, input logic aval, input logic airq,
                      input logic enwe, input logic enval,
                      input logic e_line, input logic [1:0] e_pend,
                      input logic e_atn, input string tag);
    exp_t e;
    @(negedge clk);
    obf_set_pulse = obf; host_rd_data = rdd; host_rd_status = rds;
    atn_req = areq; atn_val = aval; atn_want_irq = airq;
    irq_en_we = enwe; irq_en_d = enval;
    e.line = e_line; e.pend = e_pend; e.atn = e_atn; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: compare just after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (irq_line !== e.line || pend_dbg !== e.pend || sms_atn !== e.atn) begin
          n_fail++;
          $display("FAIL %s: got line=%b pend=%b atn=%b, want line=%b pend=%b atn=%b",
                   e.tag, irq_line, pend_dbg, sms_atn, e.line, e.pend, e.atn);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got hung, want completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_wired = 1'b1;
    obf_set_pulse = 0; host_rd_data = 0; host_rd_status = 0;
    atn_req = 0; atn_val = 0; atn_want_irq = 0; irq_en_we = 0; irq_en_d = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    //   obf rdd rds areq aval airq enwe enval | line pend atn
    step(0,0,0, 0,0,0, 0,0, 0,2'b00,0, "R1 reset state");
    step(1,0,0, 0,0,0, 0,0, 0,2'b00,0, "R1 enable clear after reset");
    step(0,0,0, 0,0,0, 1,1, 0,2'b00,0, "R2 enable write");
    step(1,0,0, 0,0,0, 0,0, 1,2'b01,0, "R2 obf pending");
    step(0,0,0, 0,0,0, 0,0, 1,2'b01,0, "R2 obf sticky");
    step(0,0,1, 0,0,0, 0,0, 1,2'b01,0, "R4 status read leaves obf");
    step(0,1,0, 0,0,0, 0,0, 0,2'b00,0, "R3 data read clears obf");
    step(0,0,0, 1,1,1, 0,0, 1,2'b10,1, "R5 atn with irq");
    step(1,0,0, 0,0,0, 0,0, 1,2'b11,1, "R2 both pending");
    step(0,1,0, 0,0,0, 0,0, 1,2'b10,1, "R3 line held by atn");
    step(1,0,0, 0,0,0, 0,0, 1,2'b11,1, "R2 obf again");
    step(0,0,1, 0,0,0, 0,0, 1,2'b01,1, "R4 line held by obf");
    step(0,1,0, 0,0,0, 0,0, 0,2'b00,1, "R3 all clear");
    step(0,0,0, 1,1,0, 0,0, 0,2'b00,1, "R5 atn without irq");
    step(0,0,0, 1,0,0, 0,0, 0,2'b00,0, "R6 atn clear");
    step(0,0,0, 1,1,1, 0,0, 1,2'b10,1, "R5 atn with irq again");
    step(1,0,0, 0,0,0, 0,0, 1,2'b11,1, "R2 obf with atn");
    step(0,0,0, 1,0,0, 0,0, 1,2'b01,0, "R6 clear keeps obf line");
    step(0,1,0, 0,0,0, 0,0, 0,2'b00,0, "R3 clear obf");
    step(1,0,0, 0,0,0, 0,0, 1,2'b01,0, "R8 obf before disable");
    step(0,0,0, 0,0,0, 1,0, 1,2'b01,0, "R8 disable keeps flag");
    step(0,0,0, 1,1,1, 0,0, 1,2'b01,1, "R8 atn blocked");
    step(0,1,0, 0,0,0, 0,0, 0,2'b00,1, "R8 read still clears");
    step(1,0,0, 0,0,0, 0,0, 0,2'b00,1, "R8 obf blocked");
    step(0,0,0, 1,0,0, 1,1, 0,2'b00,0, "R6 clear and re-enable");
    step(1,1,0, 0,0,0, 0,0, 1,2'b01,0, "R9 obf set beats read");
    step(0,0,1, 1,1,1, 0,0, 1,2'b11,1, "R9 atn set beats read");
    step(0,1,1, 0,0,0, 0,0, 0,2'b00,1, "R10 both reads");
    step(0,0,0, 1,0,0, 0,0, 0,2'b00,0, "R6 final clear");
    @(negedge clk) irq_wired = 1'b0;
    step(1,0,0, 0,0,0, 0,0, 0,2'b00,0, "R7 unwired obf");
    step(0,0,0, 1,1,1, 0,0, 0,2'b00,1, "R7 unwired atn bit only");
    step(0,0,0, 1,0,0, 0,0, 0,2'b00,0, "R7 unwired clear");
    step(0,0,0, 0,0,0, 0,0, 0,2'b00,0, "R7 idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule